// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by reading two entries from a page table that sits in memory. A requester presents the virtual address together with two flags: whether the access is a write, and whether it comes from user mode. The walker records the table base input at that moment and reads the first-level entry through a word-wide memory request/response port. If that entry is valid, it reads the second-level (leaf) entry. It then checks the leaf's permission bits and returns either a physical address or a fault code. The result stays on the outputs until the requester acknowledges it.

Pages are 4 KB. The page number is split into two 10-bit indices: bits 31:22 index the first-level table and bits 21:12 index the second-level table. Each table entry is one 32-bit word. Every entry uses the same layout:

| Bits | Meaning |
| --- | --- |
| 0 | valid |
| 1 | read allowed |
| 2 | write allowed |
| 3 | supervisor only |
| 31:12 | frame number, or base of the next table |

Bits 11:4 of an entry are ignored. The memory may take any number of cycles to answer.

The controller has five states:
- WALK_IDLE accepts a request, which moves it to WALK_FETCH_L1.
- WALK_FETCH_L1 issues one read and waits. An invalid entry takes it to WALK_DONE. A valid entry takes it to WALK_FETCH_L2.
- WALK_FETCH_L2 issues one read and waits. An invalid leaf takes it to WALK_DONE. A valid leaf takes it to WALK_CHECK.
- WALK_CHECK applies the permission check and moves to WALK_DONE.
- WALK_DONE presents the result until it is acknowledged, then returns to WALK_IDLE.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: One cycle after a request is accepted, mem_req_valid pulses high for exactly one cycle. The address it carries is tbl_base + 4 × vaddr[31:22], where tbl_base is the value sampled when the request was accepted.
- R3: After a valid first-level entry E, the walker issues exactly one second-level read. Its address is {E[31:12], 12'h000} + 4 × vaddr[21:12].
- R4: If the first-level entry has bit 0 equal to 0, the walk ends with rsp_fault = 2'b01 and rsp_paddr = 0. No second read is issued. rsp_valid rises one cycle after the response is taken.
- R5: If the leaf entry has bit 0 equal to 0, the walk ends with rsp_fault = 2'b01 and rsp_paddr = 0.
- R6: A permitted access returns rsp_fault = 2'b00 and rsp_paddr = {leaf[31:12], vaddr[11:0]}. Leaf bits 11:4 have no effect. rsp_valid rises two cycles after the leaf response is taken.
- R7: A write to a leaf with bit 2 equal to 0, or a read from a leaf with bit 1 equal to 0, returns rsp_fault = 2'b10 and rsp_paddr = 0.
- R8: A user-mode access to a leaf with bit 3 set returns rsp_fault = 2'b10. The same access in supervisor mode is translated.
- R9: Any response latency of one cycle or more is handled. A mem_rsp_valid that arrives while no read is outstanding is ignored.
- R10: While a result is presented, req_ready is 0, new requests are ignored, and rsp_valid, rsp_paddr and rsp_fault hold until rsp_ack. One cycle after rsp_ack, rsp_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 for a user-mode access |
| tbl_base | input | 32 | Physical base of the first-level table |
| mem_req_valid | output | 1 | One-cycle read request for a table entry |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 protection |
| rsp_ack | input | 1 | Requester has taken the result |

## Verification
A wrong state in the controller shows up at the ports almost at once:
- A missed or doubled read appears as a wrong number of mem_req_valid pulses during the same walk.
- A wrong index or a wrong table base shows as a mismatched address on the very read where it is used.
- A skipped or extra state moves the rise of rsp_valid by a cycle relative to the last memory response, so the bench measures that delay exactly.
- A corrupted result register shows as a changed output during the hold window, or as a stale ready after the acknowledge.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_FETCH_L1,
        WALK_FETCH_L2,
        WALK_CHECK,
        WALK_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        FLT_NONE        = 2'b00,
        FLT_NOT_PRESENT = 2'b01,
        FLT_PROTECTION  = 2'b10
    } walk_fault_t;

    // Entry flag positions
    localparam int BIT_VALID = 0;
    localparam int BIT_RD    = 1;
    localparam int BIT_WR    = 2;
    localparam int BIT_SUP   = 3;
    localparam int FLAG_BITS = 4;

endpackage

// File: rtl/pt_entry_addr.sv
// Byte address of one entry inside a table: base + index * entry size.
module pt_entry_addr #(
    parameter int ENTRY_W     = 32,
    parameter int IDX_BITS    = 10,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [ENTRY_W-1:0]  table_base,
    input  logic [IDX_BITS-1:0] index,
    output logic [ENTRY_W-1:0]  entry_addr
);
    localparam int PAD_W = ENTRY_W - IDX_BITS - ENTRY_SHIFT;

    logic [ENTRY_W-1:0] offset;

    assign offset     = {{PAD_W{1'b0}}, index, {ENTRY_SHIFT{1'b0}}};
    assign entry_addr = table_base + offset;
endmodule

// File: rtl/pt_perm_check.sv
// Decides whether a valid leaf allows the access.
module pt_perm_check
    import pt_walker_pkg::*;
(
    input  logic       allow_rd,
    input  logic       allow_wr,
    input  logic       sup_only,
    input  logic       is_write,
    input  logic       is_user,
    output logic [1:0] fault
);
    logic type_ok;
    logic mode_ok;

    always_comb begin
        type_ok = is_write ? allow_wr : allow_rd;
        mode_ok = !(is_user && sup_only);
        if (type_ok && mode_ok) begin
            fault = FLT_NONE;
        end else begin
            fault = FLT_PROTECTION;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int IDX_BITS  = 10,
    parameter int ENTRY_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ENTRY_W-1:0]   req_vaddr,
    input  logic                 req_write,
    input  logic                 req_user,
    input  logic [ENTRY_W-1:0]   tbl_base,
    output logic                 mem_req_valid,
    output logic [ENTRY_W-1:0]   mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [ENTRY_W-1:0]   mem_rsp_data,
    output logic                 rsp_valid,
    output logic [ENTRY_W-1:0]   rsp_paddr,
    output logic [1:0]           rsp_fault,
    input  logic                 rsp_ack
);
    localparam int LEVELS      = 2;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_W / 8);
    localparam int FRAME_W     = ENTRY_W - PAGE_BITS;

    walk_state_t state_q, state_d;

    logic [ENTRY_W-1:0]  va_q;
    logic                wr_q;
    logic                usr_q;
    logic [ENTRY_W-1:0]  base_q;
    logic [FRAME_W-1:0]  leaf_frame_q;
    logic [FLAG_BITS-1:0] leaf_flags_q;
    logic                issued_q;
    logic [1:0]          fault_q;
    logic [ENTRY_W-1:0]  pa_q;

    logic                rsp_take;
    logic                entry_ok;
    logic [1:0]          perm_fault;
    logic [ENTRY_W-1:0]  lvl_addr [LEVELS];
    logic                unused_entry_bits;

    assign unused_entry_bits = ^mem_rsp_data[PAGE_BITS-1:FLAG_BITS];

    // One address generator per table level
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        pt_entry_addr #(
            .ENTRY_W    (ENTRY_W),
            .IDX_BITS   (IDX_BITS),
            .ENTRY_SHIFT(ENTRY_SHIFT)
        ) u_addr (
            .table_base(base_q),
            .index     (va_q[PAGE_BITS + (LEVELS-1-g)*IDX_BITS +: IDX_BITS]),
            .entry_addr(lvl_addr[g])
        );
    end

    pt_perm_check u_perm (
        .allow_rd(leaf_flags_q[BIT_RD]),
        .allow_wr(leaf_flags_q[BIT_WR]),
        .sup_only(leaf_flags_q[BIT_SUP]),
        .is_write(wr_q),
        .is_user (usr_q),
        .fault   (perm_fault)
    );

    // A response counts only while a read is outstanding
    assign rsp_take = issued_q && mem_rsp_valid;
    assign entry_ok = mem_rsp_data[BIT_VALID];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WALK_IDLE: begin
                if (req_valid) state_d = WALK_FETCH_L1;
            end
            WALK_FETCH_L1: begin
                if (rsp_take) state_d = entry_ok ? WALK_FETCH_L2 : WALK_DONE;
            end
            WALK_FETCH_L2: begin
                if (rsp_take) state_d = entry_ok ? WALK_CHECK : WALK_DONE;
            end
            WALK_CHECK: begin
                state_d = WALK_DONE;
            end
            WALK_DONE: begin
                if (rsp_ack) state_d = WALK_IDLE;
            end
            default: state_d = WALK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WALK_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            base_q       <= '0;
            leaf_frame_q <= '0;
            leaf_flags_q <= '0;
            issued_q     <= 1'b0;
            fault_q      <= FLT_NONE;
            pa_q         <= '0;
        end else begin
            if (state_d != state_q) begin
                issued_q <= 1'b0;
            end else if (mem_req_valid) begin
                issued_q <= 1'b1;
            end
            unique case (state_q)
                WALK_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        base_q  <= tbl_base;
                        fault_q <= FLT_NONE;
                        pa_q    <= '0;
                    end
                end
                WALK_FETCH_L1: begin
                    if (rsp_take) begin
                        if (entry_ok) begin
                            base_q <= {mem_rsp_data[ENTRY_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
                        end else begin
                            fault_q <= FLT_NOT_PRESENT;
                        end
                    end
                end
                WALK_FETCH_L2: begin
                    if (rsp_take) begin
                        if (entry_ok) begin
                            leaf_frame_q <= mem_rsp_data[ENTRY_W-1:PAGE_BITS];
                            leaf_flags_q <= mem_rsp_data[FLAG_BITS-1:0];
                        end else begin
                            fault_q <= FLT_NOT_PRESENT;
                        end
                    end
                end
                WALK_CHECK: begin
                    fault_q <= perm_fault;
                    if (perm_fault == FLT_NONE) begin
                        pa_q <= {leaf_frame_q, va_q[PAGE_BITS-1:0]};
                    end else begin
                        pa_q <= '0;
                    end
                end
                WALK_DONE: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs from state
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = lvl_addr[0];
        rsp_valid     = 1'b0;
        unique case (state_q)
            WALK_IDLE:     req_ready = 1'b1;
            WALK_FETCH_L1: mem_req_valid = !issued_q;
            WALK_FETCH_L2: begin
                mem_req_valid = !issued_q;
                mem_req_addr  = lvl_addr[1];
            end
            WALK_CHECK:    begin end
            WALK_DONE:     rsp_valid = 1'b1;
            default:       begin end
        endcase
    end

    assign rsp_paddr = pa_q;
    assign rsp_fault = fault_q;

endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
    parameter int ENTRY_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               mem_req_valid,
    input logic [ENTRY_W-1:0] mem_req_addr,
    input logic               rsp_valid,
    input logic [ENTRY_W-1:0] rsp_paddr,
    input logic [1:0]         rsp_fault,
    input logic               rsp_ack
);
    // R2: a read request lasts one cycle and is word aligned
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);
    // R4 and R5: a fault carries no physical address
    p_fault_no_pa_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> rsp_paddr == '0);
    // R7: only the three defined codes appear
    p_fault_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'b11);
    // R10: busy while presenting, result held until acknowledged
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready && !mem_req_valid);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ack) |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));
    p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ack) |=> req_ready && !rsp_valid);
    // R2: an accepted request starts a read on the next cycle
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> mem_req_valid);
endmodule

bind pt_walker pt_walker_checker #(.ENTRY_W(ENTRY_W)) u_checker (.*);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] tbl_base = 32'h0001_0000;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        rsp_ack = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // behavioural memory and responder state
    logic [31:0] mem [int unsigned];
    logic [31:0] req_log [$];
    int  lat_q [$];
    bit  pend = 0;
    int  pend_cnt = 0;
    logic [31:0] pend_addr = '0;
    int  last_rsp_cyc = 0;
    bit  spur = 0;

    // reference model of readiness
    bit  m_idle = 1;

    pt_walker dut (.*);

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) m_idle <= 1;
        else if (m_idle && req_valid) m_idle <= 0;
        else if (!m_idle && rsp_valid && rsp_ack) m_idle <= 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (req_ready !== m_idle) begin
                failures++;
                $display("FAIL R10 ready model actual=%0b expected=%0b", req_ready, m_idle);
            end
        end
    end

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder, driven away from the active edge
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = 32'h0;
        if (spur) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = 32'hFFFF_FFFF;
        end
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
                pend = 0;
                last_rsp_cyc = cyc;
            end else begin
                pend_cnt--;
            end
        end
        if (mem_req_valid) begin
            req_log.push_back(mem_req_addr);
            pend = 1;
            pend_addr = mem_req_addr;
            pend_cnt = (lat_q.size() > 0) ? lat_q.pop_front() : 0;
        end
    end

    function automatic logic [31:0] l1_addr(input logic [31:0] va);
        return tbl_base + {20'h0, va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] l2_addr(input logic [31:0] l1e, input logic [31:0] va);
        return {l1e[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
    endfunction

    task automatic map(input logic [31:0] va, input logic [31:0] l1e, input logic [31:0] leaf);
        mem[l1_addr(va)] = l1e;
        mem[l2_addr(l1e, va)] = leaf;
    endtask

    // Runs one walk; checks request count, addresses, result and timing.
    task automatic walk(input logic [31:0] va, input bit wr, input bit usr,
                        input int lat1, input int lat2, input string tag,
                        input logic [1:0] exp_fault, input logic [31:0] exp_pa,
                        input bit probe_hold);
        logic [31:0] l1e;
        int exp_n;
        int waited;
        int delay;
        l1e = rd(l1_addr(va));
        exp_n = l1e[0] ? 2 : 1;
        req_log.delete();
        lat_q.delete();
        lat_q.push_back(lat1);
        lat_q.push_back(lat2);
        @(negedge clk);
        req_vaddr = va; req_write = wr; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (rsp_valid !== 1'b1 && waited < 300) begin
            @(negedge clk);
            waited++;
        end
        chk(rsp_valid === 1'b1, {tag, " result arrives"}, {31'h0, rsp_valid}, 32'h1);
        delay = cyc - last_rsp_cyc;
        chk(delay == (exp_fault == 2'b01 ? 1 : 2), {tag, " result timing"}, delay,
            (exp_fault == 2'b01) ? 1 : 2);
        chk(req_log.size() == exp_n, {tag, " read count"}, req_log.size(), exp_n);
        if (req_log.size() > 0)
            chk(req_log[0] === l1_addr(va), {tag, " R2 level-1 address"}, req_log[0], l1_addr(va));
        if (exp_n == 2 && req_log.size() > 1)
            chk(req_log[1] === l2_addr(l1e, va), {tag, " R3 level-2 address"}, req_log[1], l2_addr(l1e, va));
        chk(rsp_fault === exp_fault, {tag, " fault"}, {30'h0, rsp_fault}, {30'h0, exp_fault});
        chk(rsp_paddr === exp_pa, {tag, " paddr"}, rsp_paddr, exp_pa);
        if (probe_hold) begin
            // R10/R9: new request and stray response while presenting
            req_vaddr = 32'hFFC0_0000; req_valid = 1'b1; spur = 1;
            for (int i = 0; i < 3; i++) begin
                @(negedge clk);
                chk(rsp_valid === 1'b1 && req_ready === 1'b0, "R10 hold valid busy",
                    {30'h0, rsp_valid, req_ready}, 32'h2);
                chk(rsp_paddr === exp_pa && rsp_fault === exp_fault, "R10 R9 hold result",
                    rsp_paddr, exp_pa);
            end
            req_valid = 1'b0; spur = 0;
            chk(req_log.size() == exp_n, "R10 no read while presenting", req_log.size(), exp_n);
        end
        rsp_ack = 1'b1;
        @(negedge clk);
        rsp_ack = 1'b0;
        chk(rsp_valid === 1'b0 && req_ready === 1'b1, {tag, " R10 release"},
            {30'h0, rsp_valid, req_ready}, 32'h1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] va;
        // level-1 entries: index 1 valid with junk ignored bits, index 3 invalid
        va = 32'h0040_3ABC;
        map(va, 32'h0002_0FF1, 32'h1234_5007);                 // R,W,V
        map(32'h0040_4123, 32'h0002_0FF1, 32'h1111_1002);      // leaf invalid
        map(32'h0040_5456, 32'h0002_0FF1, 32'h2222_2003);      // read only
        map(32'h0040_6789, 32'h0002_0FF1, 32'h3333_3005);      // write only
        map(32'h0040_7010, 32'h0002_0FF1, 32'h4444_400B);      // supervisor R
        map(32'h0040_8FFF, 32'h0002_0FF1, 32'h5555_5FF7);      // ignored bits set
        mem[l1_addr(32'h00C0_0000)] = 32'h0003_0FFE;           // R4 invalid L1 with junk

        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_req_valid === 1'b0,
            "R1 reset outputs", {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 idle after reset", {31'h0, req_ready}, 32'h1);

        walk(va, 0, 0, 0, 0, "R6 read", 2'b00, 32'h1234_5ABC, 0);
        walk(va, 1, 1, 5, 3, "R9 slow write user", 2'b00, 32'h1234_5ABC, 0);
        walk(32'h00C0_0000, 0, 0, 2, 0, "R4 L1 invalid", 2'b01, 32'h0, 0);
        walk(32'h0080_0000, 1, 0, 0, 0, "R4 L1 null", 2'b01, 32'h0, 0);
        walk(32'h0040_4123, 0, 0, 1, 4, "R5 leaf invalid", 2'b01, 32'h0, 0);
        walk(32'h0040_5456, 1, 0, 0, 0, "R7 write read-only", 2'b10, 32'h0, 0);
        walk(32'h0040_5456, 0, 1, 0, 0, "R7 read read-only", 2'b00, 32'h2222_2456, 0);
        walk(32'h0040_6789, 0, 0, 0, 0, "R7 read no-read", 2'b10, 32'h0, 0);
        walk(32'h0040_6789, 1, 1, 0, 0, "R7 write write-only", 2'b00, 32'h3333_3789, 0);
        walk(32'h0040_7010, 0, 1, 0, 0, "R8 user on sup", 2'b10, 32'h0, 0);
        walk(32'h0040_7010, 0, 0, 0, 0, "R8 sup on sup", 2'b00, 32'h4444_4010, 0);
        walk(32'h0040_8FFF, 1, 1, 3, 3, "R6 ignored bits", 2'b00, 32'h5555_5FFF, 1);

        // R9: stray response while idle, then a normal walk
        @(negedge clk);
        spur = 1;
        @(negedge clk);
        spur = 0;
        chk(req_ready === 1'b1 && mem_req_valid === 1'b0 && rsp_valid === 1'b0,
            "R9 stray response idle", {29'h0, req_ready, mem_req_valid, rsp_valid}, 32'h4);
        walk(va, 0, 0, 7, 1, "R9 after stray", 2'b00, 32'h1234_5ABC, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule